// File: doc/BRIEF.md
# Memory-Mapped NAND Cycle Bridge

This block lets a simple synchronous host bus drive a raw NAND flash device. Each host access is turned into exactly one NAND bus cycle. Which kind of cycle is produced (command latch, address latch or data transfer) depends only on the host address window that the access falls in, so software issues a command by writing to one window, a page address by writing to another, and moves data through a third.

Two host base regions (a common space and an attribute space) map onto the same device. Each region has its own timing word, which supplies the setup, strobe-low and hold lengths. Data transfers wait for the device's ready/busy line before they start. An access that decodes outside the mapped area completes at once with an error and does not touch the NAND pins.

Top module: `nand_cycle_bridge`

## Requirements
- R1: Host address bits [17:16] choose the cycle kind. 00 is data (cle=0, ale=0), 01 is command (cle=1, ale=0), 10 and 11 are address (ale=1, cle=0). The chosen latch levels and ce_n=0 hold from the first setup cycle through the last hold cycle.
- R2: Host address bits [15:0] have no effect on the cycle kind or on the timing.
- R3: Every access produces exactly one strobe pulse. Back-to-back writes to the address window produce one address cycle each.
- R4: nand_addr carries host_addr[25:1] when cfg_wide=1 and host_addr[24:0] when cfg_wide=0, for the whole cycle.
- R5: host_addr[27:26]=00 selects the common space, which uses tim_common. 10 selects the attribute space, which uses tim_attr. Each timing word is {hold[23:16], strobe[15:8], setup[7:0]}.
- R6: A cycle spends max(setup,1) cycles in setup, then max(strobe,1) cycles with the strobe low, then max(hold,1) cycles in hold. A field of 0 counts as 1.
- R7: In a write, nand_we_n is low only during the strobe phase, nand_re_n stays high, and nand_dq_oe is high from setup through hold. nand_dq_out equals host_wdata, with the upper byte forced to zero when cfg_wide=0.
- R8: In a read, nand_re_n is low only during the strobe phase and nand_dq_oe stays low. host_rdata is nand_dq_in sampled at the edge that ends the strobe phase, with the upper byte zero when cfg_wide=0.
- R9: host_ready is high for exactly one cycle, the cycle after the last hold cycle. host_err is low for a mapped access, and host_rdata is zero for a write.
- R10: When a data-window access is accepted while nand_rb=0, all NAND pins stay idle until nand_rb=1. Setup starts the cycle after that. Command and address accesses ignore nand_rb.
- R11: An access with host_addr[27:26] equal to 01 or 11, or with any of bits [25:18] set, gives host_ready one cycle after acceptance with host_err=1 and host_rdata=0. No NAND pin leaves idle.
- R12: In reset and when idle: nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_dq_oe=0, host_ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Access request, held until host_ready |
| host_write | input | 1 | 1 for write, 0 for read |
| host_addr | input | 28 | Byte address within the bridge's host region |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Access was unmapped (valid with host_ready) |
| host_rdata | output | 16 | Read data (valid with host_ready) |
| cfg_wide | input | 1 | 1 selects a 16-bit device bus, 0 an 8-bit bus |
| tim_common | input | 24 | Timing word for the common space |
| tim_attr | input | 24 | Timing word for the attribute space |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_addr | output | 25 | Byte or halfword address derived from host_addr |
| nand_dq_out | output | 16 | Data driven toward the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 16 | Data from the device |
| nand_rb | input | 1 | Device ready (1) or busy (0) |

## Verification
The acceptance edge is the first rising edge at which host_valid is seen. The first setup cycle is visible in the cycle after that edge. If the busy line is holding the access, setup instead starts in the cycle after nand_rb is seen high. From there the strobe starts after max(setup,1) cycles, hold starts after max(strobe,1) more, and host_ready appears after max(hold,1) more. An unmapped access raises host_ready in the cycle right after acceptance. The bench counts these cycle offsets from its own timing words and compares every pin against them on the falling edge of each cycle. It also changes nand_dq_in in the first hold cycle, which shows the read data was captured at the edge that closes the strobe and not later.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    localparam int TCNT_W = 8;

    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RBWAIT = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_DONE   = 3'd5
    } bridge_state_e;

    typedef struct packed {
        logic [TCNT_W-1:0] t_hold;
        logic [TCNT_W-1:0] t_strobe;
        logic [TCNT_W-1:0] t_setup;
    } timing_t;

    typedef struct packed {
        logic      ok;
        logic      attr;
        cyc_kind_e kind;
    } decode_t;

    function automatic logic [TCNT_W-1:0] eff_count(input logic [TCNT_W-1:0] v);
        return (v == '0) ? TCNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
    import nand_bridge_pkg::*;
#(
    parameter int HADDR_W = 28,
    parameter int EXT_W   = 25
) (
    input  logic [HADDR_W-1:0] addr,
    input  logic               wide,
    output decode_t            dec,
    output logic [EXT_W-1:0]   ext_addr
);
    localparam int SEC_LO   = 16;
    localparam int AREA_TOP = SEC_LO + 2;
    localparam int SPACE_LO = HADDR_W - 2;

    logic [1:0] region;
    logic       upper_clear;

    always_comb begin
        region      = addr[HADDR_W-1:SPACE_LO];
        upper_clear = (addr[SPACE_LO-1:AREA_TOP] == '0);
        dec.ok      = upper_clear && (region == 2'b00 || region == 2'b10);
        dec.attr    = region[1];
        if (addr[SEC_LO+1])
            dec.kind = CYC_ADDR;
        else if (addr[SEC_LO])
            dec.kind = CYC_CMD;
        else
            dec.kind = CYC_DATA;
        ext_addr = wide ? addr[EXT_W:1] : addr[EXT_W-1:0];
    end
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
    import nand_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TCNT_W-1:0] load_val,
    output logic              last
);
    logic [TCNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= eff_count(load_val);
        else if (cnt != '0)
            cnt <= cnt - TCNT_W'(1);
    end

    assign last = (cnt == TCNT_W'(1));
endmodule

// File: rtl/nand_cycle_bridge.sv
module nand_cycle_bridge
    import nand_bridge_pkg::*;
#(
    parameter int HADDR_W = 28,
    parameter int DQ_W    = 16,
    parameter int EXT_W   = 25
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_valid,
    input  logic                  host_write,
    input  logic [HADDR_W-1:0]    host_addr,
    input  logic [DQ_W-1:0]       host_wdata,
    output logic                  host_ready,
    output logic                  host_err,
    output logic [DQ_W-1:0]       host_rdata,
    input  logic                  cfg_wide,
    input  logic [3*TCNT_W-1:0]   tim_common,
    input  logic [3*TCNT_W-1:0]   tim_attr,
    output logic                  nand_ce_n,
    output logic                  nand_cle,
    output logic                  nand_ale,
    output logic                  nand_we_n,
    output logic                  nand_re_n,
    output logic [EXT_W-1:0]      nand_addr,
    output logic [DQ_W-1:0]       nand_dq_out,
    output logic                  nand_dq_oe,
    input  logic [DQ_W-1:0]       nand_dq_in,
    input  logic                  nand_rb
);
    localparam int NARROW_W = DQ_W / 2;

    decode_t          dec;
    logic [EXT_W-1:0] dec_ext;

    bridge_state_e    st, nxt;
    cyc_kind_e        kind_q;
    logic             wr_q, err_q, wide_q;
    timing_t          tim_q, tim_sel, tsrc;
    logic [DQ_W-1:0]  wdata_q, rdata_q;
    logic [EXT_W-1:0] addr_q;
    logic             t_load, t_last, active;
    logic [TCNT_W-1:0] t_val;

    nand_addr_decode #(.HADDR_W(HADDR_W), .EXT_W(EXT_W)) u_dec (
        .addr     (host_addr),
        .wide     (cfg_wide),
        .dec      (dec),
        .ext_addr (dec_ext)
    );

    nand_phase_timer u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    assign tim_sel = dec.attr ? timing_t'(tim_attr) : timing_t'(tim_common);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (host_valid) begin
                if (!dec.ok)
                    nxt = ST_DONE;
                else if (dec.kind == CYC_DATA && !nand_rb)
                    nxt = ST_RBWAIT;
                else
                    nxt = ST_SETUP;
            end
            ST_RBWAIT: if (nand_rb) nxt = ST_SETUP;
            ST_SETUP:  if (t_last) nxt = ST_STROBE;
            ST_STROBE: if (t_last) nxt = ST_HOLD;
            ST_HOLD:   if (t_last) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tsrc   = (st == ST_IDLE) ? tim_sel : tim_q;
        t_load = (nxt != st) &&
                 (nxt == ST_SETUP || nxt == ST_STROBE || nxt == ST_HOLD);
        unique case (nxt)
            ST_STROBE: t_val = tsrc.t_strobe;
            ST_HOLD:   t_val = tsrc.t_hold;
            default:   t_val = tsrc.t_setup;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind_q  <= CYC_DATA;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            wide_q  <= 1'b0;
            tim_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            addr_q  <= '0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && host_valid) begin
                kind_q  <= dec.kind;
                wr_q    <= host_write;
                err_q   <= !dec.ok;
                wide_q  <= cfg_wide;
                tim_q   <= tim_sel;
                wdata_q <= host_wdata;
                addr_q  <= dec_ext;
                rdata_q <= '0;
            end
            if (st == ST_STROBE && t_last && !wr_q)
                rdata_q <= wide_q ? nand_dq_in
                                  : {{(DQ_W-NARROW_W){1'b0}}, nand_dq_in[NARROW_W-1:0]};
        end
    end

    assign active      = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);
    assign nand_ce_n   = !active;
    assign nand_cle    = active && (kind_q == CYC_CMD);
    assign nand_ale    = active && (kind_q == CYC_ADDR);
    assign nand_we_n   = !((st == ST_STROBE) && wr_q);
    assign nand_re_n   = !((st == ST_STROBE) && !wr_q);
    assign nand_dq_oe  = active && wr_q;
    assign nand_dq_out = wide_q ? wdata_q
                                : {{(DQ_W-NARROW_W){1'b0}}, wdata_q[NARROW_W-1:0]};
    assign nand_addr   = addr_q;
    assign host_ready  = (st == ST_DONE);
    assign host_err    = (st == ST_DONE) && err_q;
    assign host_rdata  = rdata_q;
endmodule

// File: rtl/nand_cycle_bridge_chk.sv
module nand_cycle_bridge_chk (
    input logic clk,
    input logic rst,
    input logic host_valid,
    input logic host_ready,
    input logic host_err,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe
);
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale)); // R1
    AST_LATCH_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!nand_ce_n && $past(!nand_ce_n)) |-> ($stable(nand_cle) && $stable(nand_ale))); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n)); // R3
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R3
    AST_OE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        nand_dq_oe |-> !nand_ce_n); // R7
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready); // R9
    AST_READY_REQ: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> $past(host_valid)); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (host_ready && host_err) |-> (nand_ce_n && $past(nand_ce_n))); // R11
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (nand_ce_n && nand_we_n && nand_re_n && !host_ready)); // R12
endmodule

bind nand_cycle_bridge nand_cycle_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_err   (host_err),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_cycle_bridge_tb.sv
module nand_cycle_bridge_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [27:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready, host_err;
    logic [15:0] host_rdata;
    logic        cfg_wide = 1'b0;
    logic [23:0] tim_common = {8'd2, 8'd3, 8'd1};
    logic [23:0] tim_attr = 24'd0;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [24:0] nand_addr;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    nand_cycle_bridge u_dut (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_err(host_err), .host_rdata(host_rdata), .cfg_wide(cfg_wide),
        .tim_common(tim_common), .tim_attr(tim_attr), .nand_ce_n(nand_ce_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_addr(nand_addr), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog R9: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // pin vector order: ce_n cle ale we_n re_n oe ready err
    task automatic cmp8(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s pins: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cmp16(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n,
                nand_dq_oe, host_ready, host_err};
    endfunction

    task automatic check_idle(input string req);
        @(negedge clk);
        cmp8(req, pins(), 8'b1001_1000);
    endtask

    task automatic access(input string req, input logic [27:0] a, input logic wr,
                          input logic [15:0] wd, input logic [15:0] dqv, input int rbn);
        logic ok, attr, cmd, adr, wide;
        int s, w, h, nrb, total;
        logic [23:0] t;
        logic [24:0] ext;
        logic [15:0] exp_rd, exp_wd;
        logic [7:0] e;
        string tag;
        ok   = (a[25:18] == 8'd0) && (a[27:26] == 2'b00 || a[27:26] == 2'b10);
        attr = a[27];
        adr  = a[17];
        cmd  = !a[17] && a[16];
        wide = cfg_wide;
        t    = attr ? tim_attr : tim_common;
        s    = (t[7:0] == 0) ? 1 : int'(t[7:0]);
        w    = (t[15:8] == 0) ? 1 : int'(t[15:8]);
        h    = (t[23:16] == 0) ? 1 : int'(t[23:16]);
        ext  = wide ? a[25:1] : a[24:0];
        nrb  = (ok && !adr && !cmd) ? rbn : 0;
        total = ok ? (nrb + s + w + h + 1) : 1;
        exp_wd = wide ? wd : {8'h00, wd[7:0]};
        exp_rd = (ok && !wr) ? (wide ? dqv : {8'h00, dqv[7:0]}) : 16'h0000;
        @(negedge clk);
        host_addr  = a;
        host_write = wr;
        host_wdata = wd;
        host_valid = 1'b1;
        nand_dq_in = dqv;
        nand_rb    = (rbn > 0) ? 1'b0 : 1'b1;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (!ok) begin
                e = 8'b1001_1011; tag = "R11";
            end else if (k <= nrb) begin
                e = 8'b1001_1000; tag = "R10";
            end else if (k == total) begin
                e = 8'b1001_1010; tag = "R9";
            end else begin
                e = {1'b0, cmd, adr, 1'b1, 1'b1, wr, 2'b00};
                tag = (k <= nrb + s) ? "R6" : "R1";
                if (k > nrb + s && k <= nrb + s + w) begin
                    if (wr) e[4] = 1'b0; else e[3] = 1'b0;
                    tag = wr ? "R7" : "R8";
                end
            end
            cmp8({req, "/", tag}, pins(), e);
            if (!nand_ce_n) cmp16({req, "/R4"}, "nand_addr", 32'(nand_addr), 32'(ext));
            if (nand_dq_oe) cmp16({req, "/R7"}, "dq_out", 32'(nand_dq_out), 32'(exp_wd));
            if (k == total) begin
                cmp16({req, "/R8"}, "rdata", 32'(host_rdata), 32'(exp_rd));
                host_valid = 1'b0;
            end
            if (nrb > 0 && k == nrb) nand_rb = 1'b1;
            if (ok && k == nrb + s + w + 1) nand_dq_in = ~dqv;
        end
        nand_rb = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp8("R12", pins(), 8'b1001_1000);
        rst = 1'b0;
        check_idle("R12");

        // command, common space, narrow
        access("R1 cmd", 28'h0010000, 1'b1, 16'hAB70, 16'h0, 0);
        check_idle("R9");
        // five back-to-back address writes, varying offsets
        access("R3 adr0", 28'h0020000, 1'b1, 16'h0011, 16'h0, 0);
        access("R3 adr1", 28'h0030004, 1'b1, 16'h0022, 16'h0, 0);
        access("R2 adr2", 28'h002FFFF, 1'b1, 16'h0033, 16'h0, 0);
        access("R3 adr3", 28'h0031234, 1'b1, 16'h0044, 16'h0, 0);
        access("R3 adr4", 28'h0020010, 1'b1, 16'h0055, 16'h0, 0);
        // command window with offset bits set
        access("R2 cmd", 28'h001ABCD, 1'b1, 16'h0030, 16'h0, 0);
        // narrow read
        access("R8 rd8", 28'h0000000, 1'b0, 16'h0, 16'hA55A, 0);
        access("R8 rd8b", 28'h0000000, 1'b0, 16'h0, 16'h1234, 0);
        // wide read and write, address shift
        cfg_wide = 1'b1;
        access("R4 rd16", 28'h0000006, 1'b0, 16'h0, 16'hBEEF, 0);
        access("R7 wr16", 28'h000ABC2, 1'b1, 16'hC0DE, 16'h0, 0);
        // attribute space, zero timing counts
        access("R5 acmd", 28'h8010000, 1'b1, 16'h00FF, 16'h0, 0);
        tim_attr = {8'd1, 8'd4, 8'd3};
        access("R5 awr", 28'h8000010, 1'b1, 16'h8001, 16'h0, 0);
        access("R6 ard", 28'h8030000, 1'b0, 16'h0, 16'h7777, 0);
        cfg_wide = 1'b0;
        access("R7 wr8", 28'h0000003, 1'b1, 16'h5AA5, 16'h0, 0);
        // busy line
        access("R10 rdbusy", 28'h0000000, 1'b0, 16'h0, 16'h00C3, 4);
        access("R10 wrbusy", 28'h8000000, 1'b1, 16'h0099, 16'h0, 2);
        access("R10 cmdbusy", 28'h0010000, 1'b1, 16'h0090, 16'h0, 3);
        // unmapped
        access("R11 reg01", 28'h4000000, 1'b0, 16'h0, 16'hFFFF, 0);
        access("R11 above", 28'h0040000, 1'b1, 16'h1111, 16'h0, 0);
        access("R11 reg11", 28'hC010000, 1'b0, 16'h0, 16'hFFFF, 0);
        check_idle("R11");
        access("R9 after", 28'h0010000, 1'b1, 16'h00EE, 16'h0, 0);
        check_idle("R12");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule